// File: doc/BRIEF.md
# Input Capture Timer with Overflow Extension

This block is a free-running timebase that stamps rising edges on several capture inputs. A 16-bit counter advances once per clock, with no divider, while the run bit is set. A second 16-bit count records how many times it has wrapped. Each capture therefore stores a 32-bit stamp, made of the wrap count as the high half and the counter as the low half. Software can measure intervals far longer than one counter period by subtracting two stamps.

Every event has its own status bit: the overflow, the capture on each channel, and an overcapture on each channel. An overcapture means a channel captured again before its previous result was acknowledged. Status bits are cleared only by writing 1 to them. When a hardware event and a clear hit the same bit in the same cycle, the hardware event wins. An event can therefore never be lost to a clear aimed at a neighbouring bit or to a racing acknowledge. One interrupt line is raised while any enabled status bit is set. The interrupt handler reads the status word to find which source caused it.

Software reaches the block through a plain register port. The write strobe carries an address and data. The read address selects combinational read data, and reads have no side effects.

Top module: `capture_timer`

## Requirements
- R1: While control bit 0 (run) is 1, the 16-bit counter advances by one each clock. While it is 0, the counter and the wrap count hold.
- R2: When the counter steps from 0xFFFF to 0x0000, status bit 0 (overflow) is set and the 16-bit wrap count increments in the same clock.
- R3: A rising edge on cap_in[ch] is detected after a two-flop synchronizer and an edge detector. Three clocks after the input rises, the capture register at address 2+ch holds {wrap count, counter} as they stood one clock earlier, and status bit 1+ch is set.
- R4: A capture taken at the wrap is self-consistent. A stored low half of 0x0000 pairs with the already incremented wrap count. A stored low half of 0xFFFF pairs with the previous wrap count.
- R5: Writing to the status register (address 1) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: If a status bit is set by hardware in the same clock in which software clears it, the bit stays 1. A capture that meets a clear of its own flag does not raise overcapture.
- R7: A capture on a channel whose capture flag is already set, and is not being cleared in that clock, sets status bit 1+NUM_CH+ch (overcapture). That bit is also cleared by writing 1.
- R8: irq is 1 exactly when the overflow flag is set with control bit 1 set, or when a channel's capture or overcapture flag is set with control bit 2+ch set.
- R9: Address 0 reads the control register and address 1 reads the status register, with unused upper bits reading 0. Reads change no state. Any address not in the map reads 0.
- R10: After reset the control, status and capture registers read 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | NUM_CH | Asynchronous capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 2*CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 2*CNT_W | Combinational read data |
| irq | output | 1 | Level interrupt, any enabled status bit set |

## Verification
The capture properties assume that each capture input stays at one level long enough for the synchronizer to pass both the low and the high phase. The stimulus holds every pulse high for two clocks and keeps it low for at least one clock before the next rise. The wrap properties assume that the run bit changes only through register writes. Run stays set during both wraps. Captures and status clears are aimed at the exact clocks of the wrap, so the two racing cases are both exercised: a set against a clear, and a capture that lands on the wrap.

// File: rtl/ct_pkg.sv
// Shared register map and status bit positions for the capture timer.
// Assumes word addressing on the register port.
package ct_pkg;
    localparam int CT_ADDR_CTRL    = 0;
    localparam int CT_ADDR_STAT    = 1;
    localparam int CT_ADDR_CAP0    = 2;
    localparam int CT_CTRL_RUN     = 0;
    localparam int CT_CTRL_OVF_IE  = 1;
    localparam int CT_CTRL_CAP_IE0 = 2;
    localparam int CT_STAT_OVF     = 0;
    localparam int CT_STAT_CAP0    = 1;
endpackage

// File: rtl/ct_w1c_flag.sv
// One sticky status bit. A hardware set takes priority over a software clear
// in the same clock. Assumes set and clr are synchronous to clk.
module ct_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag; the set has priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/ct_counter.sv
// Full-rate counter with a wrap count extension. wrap is high in the cycle
// whose clock edge takes the low half from all ones to zero.
// Assumes run is a registered control bit.
module ct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] lo,
    output logic [CNT_W-1:0] hi,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TOP = '1;

    assign wrap = run && (lo == TOP);

    // Advance the low half; bump the high half on the same edge as the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else if (run) begin
            lo <= lo + CNT_W'(1);
            if (wrap) hi <= hi + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ct_channel.sv
// One capture channel. The input is synchronized by two flops, then a rising
// edge loads the stamp and sets the capture flag. A capture landing on a set,
// uncleared flag raises overcapture. Assumes the stamp is registered
// upstream, so both halves change together.
module ct_channel #(
    parameter int STAMP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_in,
    input  logic [STAMP_W-1:0] stamp,
    input  logic               clr_cap,
    input  logic               clr_ovr,
    output logic               evt,
    output logic [STAMP_W-1:0] cap_val,
    output logic               cap_flag,
    output logic               ovr_flag
);
    logic [1:0] sync_q;
    logic       prev_q;

    // Synchronize the asynchronous input and keep its last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], cap_in};
            prev_q <= sync_q[1];
        end
    end

    assign evt = sync_q[1] & ~prev_q;

    // Load the stamp on a detected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_val <= '0;
        else if (evt) cap_val <= stamp;
    end

    ct_w1c_flag cap_f (
        .clk(clk), .rst_n(rst_n), .set(evt), .clr(clr_cap), .q(cap_flag)
    );

    ct_w1c_flag ovr_f (
        .clk(clk), .rst_n(rst_n), .set(evt & cap_flag & ~clr_cap),
        .clr(clr_ovr), .q(ovr_flag)
    );
endmodule

// File: rtl/capture_timer.sv
// Input capture timer top. It holds the control register and builds the
// status word and the combined interrupt. It decodes register writes and
// drives the combinational read mux.
// Assumes NUM_CH + 2 <= 2**ADDR_W and 1 + 2*NUM_CH <= 2*CNT_W.
module capture_timer
    import ct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    cap_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [2*CNT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [2*CNT_W-1:0]   rd_data,
    output logic                 irq
);
    localparam int DW = 2 * CNT_W;
    localparam int SW = 1 + 2 * NUM_CH;
    localparam int CW = CT_CTRL_CAP_IE0 + NUM_CH;

    logic [CW-1:0]        ctrl_q;
    logic                 run, ovf_ie, wrap, ovf_flag, stat_wr;
    logic [CNT_W-1:0]     cnt_lo, cnt_hi;
    logic [SW-1:0]        clr_vec, stat;
    logic [NUM_CH-1:0]    cap_evt, cap_flags, ovr_flags, ch_pend;
    logic [NUM_CH*DW-1:0] cap_flat;
    wire                  unused_wr_bits = ^wr_data[DW-1:SW];

    assign run     = ctrl_q[CT_CTRL_RUN];
    assign ovf_ie  = ctrl_q[CT_CTRL_OVF_IE];
    assign stat_wr = wr_en && (wr_addr == ADDR_W'(CT_ADDR_STAT));
    assign clr_vec = stat_wr ? wr_data[SW-1:0] : '0;

    // Control register: run bit and per-source interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_W'(CT_ADDR_CTRL)) ctrl_q <= wr_data[CW-1:0];
    end

    ct_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run(run), .lo(cnt_lo), .hi(cnt_hi), .wrap(wrap)
    );

    ct_w1c_flag ovf_i (
        .clk(clk), .rst_n(rst_n), .set(wrap), .clr(clr_vec[CT_STAT_OVF]), .q(ovf_flag)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        ct_channel #(.STAMP_W(DW)) ch_i (
            .clk(clk), .rst_n(rst_n), .cap_in(cap_in[ch]), .stamp({cnt_hi, cnt_lo}),
            .clr_cap(clr_vec[CT_STAT_CAP0 + ch]), .clr_ovr(clr_vec[CT_STAT_CAP0 + NUM_CH + ch]),
            .evt(cap_evt[ch]), .cap_val(cap_flat[ch*DW +: DW]),
            .cap_flag(cap_flags[ch]), .ovr_flag(ovr_flags[ch])
        );
    end

    assign stat    = {ovr_flags, cap_flags, ovf_flag};
    assign ch_pend = (cap_flags | ovr_flags) & ctrl_q[CW-1:CT_CTRL_CAP_IE0];
    assign irq     = (ovf_flag & ovf_ie) | (|ch_pend);

    // Read mux without side effects; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CT_ADDR_CTRL))      rd_data = DW'(ctrl_q);
        else if (rd_addr == ADDR_W'(CT_ADDR_STAT)) rd_data = DW'(stat);
        else begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (rd_addr == ADDR_W'(CT_ADDR_CAP0 + ch)) rd_data = cap_flat[ch*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/ct_checker.sv
// Temporal properties of the capture timer, bound to the top module.
// Assumes synchronous active-low reset and the default register map.
module ct_checker #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic                   ovf_ie,
    input logic                   irq,
    input logic [CNT_W-1:0]       cnt_lo,
    input logic [CNT_W-1:0]       cnt_hi,
    input logic                   ovf_flag,
    input logic [2*NUM_CH:0]      clr_vec,
    input logic [NUM_CH-1:0]      cap_evt,
    input logic [NUM_CH-1:0]      cap_flags,
    input logic [NUM_CH-1:0]      ovr_flags,
    input logic [NUM_CH*2*CNT_W-1:0] cap_flat
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam int DW = 2 * CNT_W;

    // R1
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_lo) && $stable(cnt_hi));
    // R1
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_lo != TOP) |=> cnt_lo == $past(cnt_lo) + CNT_W'(1));
    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_lo == TOP) |=> cnt_lo == '0 && ovf_flag && cnt_hi == $past(cnt_hi) + CNT_W'(1));
    // R5
    ovf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(clr_vec[0]));
    // R8
    irq_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && ovf_ie) |-> irq);
    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag || (|cap_flags) || (|ovr_flags)));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R3
        cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_evt[ch] |=> cap_flags[ch] && cap_flat[ch*DW +: DW] == $past({cnt_hi, cnt_lo}));
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_evt[ch] && clr_vec[1+ch]) |=> cap_flags[ch]);
        // R7
        ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_evt[ch] && cap_flags[ch] && !clr_vec[1+ch]) |=> ovr_flags[ch]);
    end
endmodule

bind capture_timer ct_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .ovf_ie(ovf_ie), .irq(irq),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag), .clr_vec(clr_vec),
    .cap_evt(cap_evt), .cap_flags(cap_flags), .ovr_flags(ovr_flags), .cap_flat(cap_flat)
);

// File: tb/capture_timer_tb_top.sv
// Self-checking bench: a reference count model plus expected register
// images. It mixes seeded random captures and clears with directed cases
// at the counter wrap.
module capture_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cap_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] ref_cnt;
    logic        ref_en;
    logic [3:0]  exp_ctrl = '0;
    logic [4:0]  exp_stat = '0;
    logic [31:0] exp_cap [2];

    always #2.5 clk = ~clk;

    capture_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // Reference timebase built from the run bit written through the port.
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            ref_en  <= 1'b0;
        end else begin
            if (ref_en) ref_cnt <= ref_cnt + 32'd1;
            if (wr_en && wr_addr == 4'd0) ref_en <= wr_data[0];
        end
    end

    function automatic logic [4:0] next_stat(logic [4:0] old, logic [1:0] mask,
                                             logic [4:0] clr, logic ovf_set);
        logic [4:0] n = old & ~clr;
        if (ovf_set) n[0] = 1'b1;
        for (int ch = 0; ch < 2; ch++) begin
            if (mask[ch]) begin
                n[1+ch] = 1'b1;
                if (old[1+ch] && !clr[1+ch]) n[3+ch] = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic exp_irq(logic [4:0] s, logic [3:0] c);
        return (s[0] & c[1]) | ((s[1] | s[3]) & c[2]) | ((s[2] | s[4]) & c[3]);
    endfunction

    task automatic check_eq(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic read_reg(logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        read_reg(4'd0, d); check_eq(req, "ctrl", d, {28'd0, exp_ctrl});
        read_reg(4'd1, d); check_eq(req, "status", d, {27'd0, exp_stat});
        read_reg(4'd2, d); check_eq(req, "cap0", d, exp_cap[0]);
        read_reg(4'd3, d); check_eq(req, "cap1", d, exp_cap[1]);
        check_eq(req, "irq", {31'd0, irq}, {31'd0, exp_irq(exp_stat, exp_ctrl)});
    endtask

    // Called at a falling edge; ends at a falling edge.
    task automatic do_write(logic [3:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 4'd0) exp_ctrl = d[3:0];
        if (a == 4'd1) exp_stat = exp_stat & ~d[4:0];
    endtask

    // Raise inputs at a falling edge; a status clear, if any, lands on the capture clock.
    task automatic cap_pulse(logic [1:0] mask, logic [4:0] clr, logic ovf_set, string req);
        logic [31:0] stamp;
        cap_in = mask;
        @(posedge clk);
        @(posedge clk);
        #1 stamp = ref_cnt;
        @(negedge clk);
        cap_in = '0;
        if (clr != '0) begin
            wr_en = 1'b1; wr_addr = 4'd1; wr_data = {27'd0, clr};
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        exp_stat = next_stat(exp_stat, mask, clr, ovf_set);
        for (int ch = 0; ch < 2; ch++) if (mask[ch]) exp_cap[ch] = stamp;
        check_all(req);
    endtask

    task automatic random_phase(int iters, logic keep_ovf);
        for (int i = 0; i < iters; i++) begin
            logic [4:0] clr;
            repeat ($urandom_range(0, 199)) @(negedge clk);
            clr = 5'($urandom) & 5'($urandom);
            if (keep_ovf) clr[0] = 1'b0;
            if ($urandom_range(0, 7) == 0) begin
                do_write(4'd0, {28'd0, 3'($urandom), 1'b1});
                check_all("R8");
            end
            cap_pulse(2'($urandom_range(1, 3)), clr, 1'b0, "R3");
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240607));
        exp_cap[0] = '0;
        exp_cap[1] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        check_all("R10");
        read_reg(4'd9, d); check_eq("R9", "unmapped", d, 32'd0);

        // Counter stopped: stamps stay at zero; a second capture sets overcapture.
        cap_pulse(2'b10, 5'd0, 1'b0, "R1");
        repeat (10) @(negedge clk);
        cap_pulse(2'b10, 5'd0, 1'b0, "R7");
        do_write(4'd1, 32'd0);
        check_all("R5");
        do_write(4'd0, 32'hF);
        check_all("R8");
        do_write(4'd1, 32'h4);
        check_all("R5");
        do_write(4'd1, 32'h10);
        check_all("R7");

        // A capture that meets a clear of its own flag keeps the flag, no overcapture.
        cap_pulse(2'b01, 5'd0, 1'b0, "R3");
        cap_pulse(2'b01, 5'b00010, 1'b0, "R6");
        do_write(4'd1, 32'h1F);
        check_all("R5");

        random_phase(120, 1'b0);

        // First wrap: a capture that stores low half zero pairs with wrap count one.
        while (ref_cnt[15:0] != 16'hFFFE) @(negedge clk);
        cap_pulse(2'b01, 5'd0, 1'b1, "R2");
        check_eq("R4", "cap0 at wrap", exp_cap[0], {16'd1, 16'd0});

        random_phase(80, 1'b1);

        // Second wrap: the overflow clear lands on the wrap clock; ch1 stamps 0xFFFF.
        while (ref_cnt[15:0] != 16'hFFFD) @(negedge clk);
        cap_pulse(2'b10, 5'b00001, 1'b1, "R6");
        check_eq("R4", "cap1 before wrap", exp_cap[1], {16'd1, 16'hFFFF});
        do_write(4'd1, 32'h1);
        check_all("R5");

        // Stop the counter again; stamps freeze.
        do_write(4'd0, 32'hE);
        repeat (20) @(negedge clk);
        cap_pulse(2'b11, 5'h1E, 1'b0, "R1");
        check_eq("R1", "frozen pair", exp_cap[0], exp_cap[1]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule